// File: doc/BRIEF.md
# Lookup-Table Multi-Word Trigger Recognizer

This block watches a 32-bit sampled data word and raises one active-low hit line for each of three independently programmed trigger words. It does not use comparators. Each trigger word is cut into four 8-bit slices, and each slice owns a 256 x 1 lookup memory addressed by its byte of the sample. A stored 0 at an address means "this byte value is acceptable". A word hits when all four of its slices read 0 for the same sample.

The host fills the memories one address at a time. It clears the shared slice address counters, writes one bit into one slice of one word at the current address, and repeats this for every slice. It then advances the counters and continues until all 256 addresses are done.

Acquisition starts when the mode input goes high. On that edge the counters return to zero. From then on, each clock latches the data input, and the latched bytes address the memories. Because a slice can hold 0 at several addresses, don't-care bytes and value sets need no extra logic.

Top module: `trigword_recognizer`

## Requirements
- R1: After reset, every hit line is 1, the address counters are 0 and every memory location holds 1. An unloaded recognizer never hits, even for a data word of all zeros.
- R2: In load mode (run_i=0), a cycle with wr_en_i=1 stores wr_bit_i in the memory selected by wr_word_i and wr_slice_i, at that slice's current counter address. The word encoding is 0=A, 1=B, 2=C. Slice s covers data bits 8s+7:8s, so slice 0 is bits 7:0 and slice 3 is bits 31:24.
- R3: In load mode, cnt_clr_i sets all slice counters to 0, and cnt_inc_i advances them by one. The counters wrap from 255 to 0. If both are asserted in the same cycle, clear wins.
- R4: In run mode, data_i is latched on a clock edge k. After edge k+1, match_n_o[w] is 0 exactly when all four slice memories of word w read 0 at the latched bytes.
- R5: Whenever the block was in load mode at the previous edge, every match_n_o bit is driven to 1 after the next edge.
- R6: In run mode, wr_en_i, cnt_inc_i and cnt_clr_i have no effect on the memories or on the counters.
- R7: The edge on which run_i is first seen high after load mode sets all slice counters to 0.
- R8: A slice holding 0 at more than one address accepts every one of those byte values.
- R9: The three words are independent. A sample can hit any subset of A, B and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and load clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = run (latched compare), 0 = load |
| cnt_clr_i | input | 1 | Clear slice address counters (load mode) |
| cnt_inc_i | input | 1 | Advance slice address counters (load mode) |
| wr_en_i | input | 1 | Write one memory bit (load mode) |
| wr_word_i | input | 2 | Target word: 0=A, 1=B, 2=C |
| wr_slice_i | input | 2 | Target slice, 0 = bits 7:0 |
| wr_bit_i | input | 1 | Bit value to store |
| data_i | input | 32 | Sampled channel word |
| match_n_o | output | 3 | Active-low hit per word, bit 0 = A |

## Verification
The assertions assume that the host holds cnt_clr_i, cnt_inc_i and wr_en_i to single-cycle meaning. They also assume that run_i changes only between whole load or acquisition phases, so the two-edge delay from a low run_i to inactive outputs is never cut short by a reset. The bench drives every input on the falling edge. It leaves each sample in place for the two edges it needs to reach the output, and it changes run_i only with all host strobes low. The single exception is the deliberate check that strobes are ignored in run mode.

// File: rtl/trigrec_pkg.sv
package trigrec_pkg;
    localparam int TR_WORDS_DEF = 3;
    localparam int TR_WIDTH_DEF = 32;
    localparam int TR_SLICE_DEF = 8;

    typedef enum logic {
        TR_LOAD = 1'b0,
        TR_RUN  = 1'b1
    } tr_mode_e;
endpackage

// File: rtl/trigrec_addr_ctr.sv
module trigrec_addr_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clr_i) begin
            ctr_d.cnt = '0;
        end else if (inc_i) begin
            ctr_d.cnt = ctr_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_o = ctr_q.cnt;

    // R3: clear has priority and lands in one edge
    a_r3_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

    // R3: increment steps by one, wrapping at the top
    a_r3_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (cnt_o == W'($past(cnt_o) + W'(1))));
endmodule

// File: rtl/trigrec_slice_mem.sv
module trigrec_slice_mem #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic          wbit_i,
    input  logic [AW-1:0] raddr_i,
    output logic          rbit_o
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0] bits;
    } mem_t;

    mem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d.bits[waddr_i] = wbit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rbit_o = mem_q.bits[raddr_i];

    // R2: a write lands at the addressed location
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q.bits[$past(waddr_i)] == $past(wbit_i)));

    // R6: contents only move on a write strobe
    a_r6_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mem_q.bits));
endmodule

// File: rtl/trigrec_word.sv
module trigrec_word #(
    parameter int NUM_SLICES = 4,
    parameter int SLICE_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLICES-1:0]         we_i,
    input  logic [NUM_SLICES*SLICE_W-1:0] waddr_i,
    input  logic                          wbit_i,
    input  logic [NUM_SLICES*SLICE_W-1:0] raddr_i,
    output logic                          miss_o
);
    logic [NUM_SLICES-1:0] slice_rd;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        trigrec_slice_mem #(.AW(SLICE_W)) u_mem (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (we_i[s]),
            .waddr_i (waddr_i[s*SLICE_W +: SLICE_W]),
            .wbit_i  (wbit_i),
            .raddr_i (raddr_i[s*SLICE_W +: SLICE_W]),
            .rbit_o  (slice_rd[s])
        );
    end

    // active-low: any slice that reads 1 vetoes the hit
    assign miss_o = |slice_rd;
endmodule

// File: rtl/trigword_recognizer.sv
module trigword_recognizer
    import trigrec_pkg::*;
#(
    parameter int NUM_WORDS = TR_WORDS_DEF,
    parameter int WORD_W    = TR_WIDTH_DEF,
    parameter int SLICE_W   = TR_SLICE_DEF
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         run_i,
    input  logic                                         cnt_clr_i,
    input  logic                                         cnt_inc_i,
    input  logic                                         wr_en_i,
    input  logic [((NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1)-1:0] wr_word_i,
    input  logic [((WORD_W / SLICE_W > 1) ? $clog2(WORD_W / SLICE_W) : 1)-1:0] wr_slice_i,
    input  logic                                         wr_bit_i,
    input  logic [WORD_W-1:0]                            data_i,
    output logic [NUM_WORDS-1:0]                         match_n_o
);
    localparam int NUM_SLICES = WORD_W / SLICE_W;
    localparam int WSEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int SSEL_W     = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

    typedef struct packed {
        tr_mode_e             mode;
        logic [WORD_W-1:0]    data;
        logic [NUM_WORDS-1:0] match_n;
    } top_t;

    top_t st_d, st_q;

    logic                          run_entry;
    logic                          ctr_clr;
    logic                          ctr_inc;
    logic [NUM_SLICES*SLICE_W-1:0] cnt_flat;
    logic [NUM_WORDS-1:0]          word_miss;

    always_comb begin
        run_entry = run_i && (st_q.mode == TR_LOAD);
        ctr_clr   = (cnt_clr_i && !run_i) || run_entry;
        ctr_inc   = cnt_inc_i && !run_i;

        st_d      = st_q;
        st_d.mode = run_i ? TR_RUN : TR_LOAD;
        if (run_i) begin
            st_d.data = data_i;
        end
        st_d.match_n = (st_q.mode == TR_RUN) ? word_miss : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode    <= TR_LOAD;
            st_q.data    <= '0;
            st_q.match_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_ctr
        trigrec_addr_ctr #(.W(SLICE_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (ctr_clr),
            .inc_i (ctr_inc),
            .cnt_o (cnt_flat[s*SLICE_W +: SLICE_W])
        );
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [NUM_SLICES-1:0] we_vec;
        for (genvar s = 0; s < NUM_SLICES; s++) begin : g_we
            assign we_vec[s] = wr_en_i && !run_i
                               && (wr_word_i == WSEL_W'(w))
                               && (wr_slice_i == SSEL_W'(s));
        end
        trigrec_word #(.NUM_SLICES(NUM_SLICES), .SLICE_W(SLICE_W)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (we_vec),
            .waddr_i (cnt_flat),
            .wbit_i  (wr_bit_i),
            .raddr_i (st_q.data),
            .miss_o  (word_miss[w])
        );
    end

    assign match_n_o = st_q.match_n;

    // R5: load mode drives every hit line inactive two edges later
    a_r5_load_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> ##2 (match_n_o == '1));

    // R7: the first run edge returns the counters to zero
    a_r7_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (st_q.mode == TR_LOAD)) |=> (cnt_flat == '0));

    // R6: host strobes cannot move the counters during acquisition
    a_r6_cnt_frozen_run: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (st_q.mode == TR_RUN)) |=> $stable(cnt_flat));
endmodule

// File: tb/trigword_recognizer_bench.sv
`timescale 1ns/1ps
module trigword_recognizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        cnt_clr_i = 1'b0;
    logic        cnt_inc_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_word_i = '0;
    logic [1:0]  wr_slice_i = '0;
    logic        wr_bit_i = 1'b0;
    logic [31:0] data_i = '0;
    logic [2:0]  match_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] tw [3];

    always #4 clk = ~clk;

    trigword_recognizer u_trigword_recognizer (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .cnt_clr_i(cnt_clr_i),
        .cnt_inc_i(cnt_inc_i), .wr_en_i(wr_en_i), .wr_word_i(wr_word_i),
        .wr_slice_i(wr_slice_i), .wr_bit_i(wr_bit_i), .data_i(data_i),
        .match_n_o(match_n_o)
    );

    // {data, expected match_n {C,B,A}}
    localparam logic [34:0] VEC [8] = '{
        {32'hA5C3_0F11, 3'b110},
        {32'h0000_00FF, 3'b101},
        {32'hDEAD_BEEF, 3'b011},
        {32'hA5C3_0F10, 3'b111},
        {32'h0000_0000, 3'b111},
        {32'hDEAD_BEEE, 3'b111},
        {32'hFFFF_FFFF, 3'b111},
        {32'hA5C3_0F11, 3'b110}
    };

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: match_n=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); cnt_clr_i = 1'b1;
        @(negedge clk); cnt_clr_i = 1'b0;
    endtask

    task automatic pulse_inc();
        @(negedge clk); cnt_inc_i = 1'b1;
        @(negedge clk); cnt_inc_i = 1'b0;
    endtask

    task automatic host_write(input int w, input int s, input logic b);
        @(negedge clk);
        wr_en_i = 1'b1; wr_word_i = 2'(w); wr_slice_i = 2'(s); wr_bit_i = b;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic load_all(input bit extra_en, input logic [7:0] extra_addr);
        pulse_clr();
        for (int a = 0; a < 256; a++) begin
            for (int w = 0; w < 3; w++) begin
                for (int s = 0; s < 4; s++) begin
                    logic b;
                    b = (tw[w][s*8 +: 8] != 8'(a));
                    if (extra_en && w == 2 && s == 1 && extra_addr == 8'(a)) b = 1'b0;
                    host_write(w, s, b);
                end
            end
            pulse_inc();
        end
    endtask

    task automatic sample(input logic [31:0] d, input logic [2:0] exp, input string tag);
        @(negedge clk); data_i = d;
        @(negedge clk);
        @(negedge clk);
        check(tag, match_n_o, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: match_n=%b expected completion", match_n_o);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tw[0] = 32'hA5C3_0F11;
        tw[1] = 32'h0000_00FF;
        tw[2] = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", match_n_o, 3'b111);
        rst_n = 1'b1;
        @(negedge clk); run_i = 1'b1;
        sample(32'h0, 3'b111, "R1 unloaded memories never hit");
        @(negedge clk); run_i = 1'b0;

        // R2 load, then R5 load mode keeps outputs inactive
        load_all(1'b0, 8'h00);
        @(negedge clk); data_i = tw[0];
        repeat (3) @(negedge clk);
        check("R5 inactive in load mode", match_n_o, 3'b111);

        // R4 / R9 vector walk
        @(negedge clk); run_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sample(VEC[i][34:3], VEC[i][2:0], "R4 R9 vector");
        end

        // R5 falling back to load while a hit is present
        @(negedge clk); run_i = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R5 return to load forces inactive", match_n_o, 3'b111);

        // R8 extra zero for C slice 1 at 0x00; R3 wrap: counters back at 0
        load_all(1'b1, 8'h00);
        host_write(0, 3, 1'b0);
        @(negedge clk); run_i = 1'b1;
        sample(32'hDEAD_00EF, 3'b011, "R8 alternate byte accepted");
        sample(32'hDEAD_BEEF, 3'b011, "R8 original byte still accepted");
        sample(32'hDEAD_01EF, 3'b111, "R8 other byte rejected");
        sample(32'h00C3_0F11, 3'b110, "R3 wrap to address 0");
        @(negedge clk); run_i = 1'b0;

        // R3 clear priority and increment counting
        pulse_clr();
        pulse_inc(); pulse_inc(); pulse_inc();
        @(negedge clk); cnt_clr_i = 1'b1; cnt_inc_i = 1'b1;
        @(negedge clk); cnt_clr_i = 1'b0; cnt_inc_i = 1'b0;
        pulse_inc(); pulse_inc();
        host_write(1, 0, 1'b0);
        @(negedge clk); run_i = 1'b1;
        sample(32'h0000_0002, 3'b101, "R3 write at address 2");
        sample(32'h0000_0003, 3'b111, "R3 address 3 untouched");
        sample(32'h0000_0000, 3'b111, "R3 address 0 untouched");
        @(negedge clk); run_i = 1'b0;

        // R7 run entry clears counters
        repeat (7) pulse_inc();
        @(negedge clk); run_i = 1'b1;
        @(negedge clk); run_i = 1'b0;
        host_write(1, 0, 1'b0);
        @(negedge clk); run_i = 1'b1;
        sample(32'h0000_0000, 3'b101, "R7 counters zero after run entry");

        // R6 strobes during run are ignored
        @(negedge clk);
        wr_en_i = 1'b1; wr_word_i = 2'd1; wr_slice_i = 2'd0; wr_bit_i = 1'b1;
        cnt_inc_i = 1'b1; cnt_clr_i = 1'b1;
        repeat (3) @(negedge clk);
        wr_en_i = 1'b0; cnt_inc_i = 1'b0; cnt_clr_i = 1'b0;
        sample(32'h0000_0000, 3'b101, "R6 write in run ignored");
        sample(32'h0000_0002, 3'b101, "R6 other entry intact");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule